// File: doc/BRIEF.md
# Two-wire serial EEPROM slave

This block models a byte-organized serial EEPROM that sits on a two-wire bus as a slave. It works in the system clock domain. Its inputs are already-synchronized copies of the bus clock and data lines. It drives a single active-high enable that pulls the open-drain data line low. The array size is a parameter: 128, 256, 512, 1024 or 2048 bytes. From that size the block derives the word-address width, the page size and the number of select pins it compares.

A master first sends a device-select byte. A write then sends one word-address byte followed by data bytes. The data bytes are collected in a page buffer. After a STOP, they are committed to the array at the end of a self-timed internal write cycle whose length in clocks is a parameter. A read returns bytes from the current address pointer, which advances after each byte. A random read uses a write that carries only the address, then a repeated START. A write-protect input stops all array updates.

Top module: `eeprom2w_slave`

## Requirements
- R1: After reset the data line is released (sdaDrvLow = 0), the slave is idle, and every array byte reads 0xFF.
- R2: The slave acknowledges a device-select byte only when bits 7..4 are 1010 and the used select positions match the pins. Bit 3 pairs with selPins[2], bit 2 with selPins[1] and bit 1 with selPins[0]. Unused positions carry word-address bits instead: bit 1 is address bit 8, bit 2 is bit 9 and bit 3 is bit 10. For a 512-byte array only bits 3..2 are compared. Bit 0 is 1 for a read.
- R3: Every address and data byte the master writes is acknowledged by pulling the data line low during the ninth clock.
- R4: A byte written and closed by a STOP reads back its new value once the internal write cycle has ended.
- R5: A page write may be shorter than a page (16 bytes at 512 bytes) and updates only the bytes received. The address wraps to the start of the current page.
- R6: For WR_CYCLES clocks after the STOP that ends a write, the device-select byte is not acknowledged. Afterwards it is acknowledged again.
- R7: While wpIn is 1, data bytes are still acknowledged, the array is left unchanged, and no internal write cycle starts.
- R8: A random read (address write, repeated START, read select) returns the byte at that address.
- R9: A sequential read returns successive bytes, wraps from the last address to address 0, and ends at a master NACK.
- R10: A current-address read continues from the address after the last byte read.
- R11: Incoming bits are taken on the rising bus-clock edge. The data-line enable changes only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Synchronized bus clock |
| sdaIn | input | 1 | Synchronized bus data line (wired value) |
| selPins | input | 3 | Hardwired select pins |
| wpIn | input | 1 | Write protect, 1 = array locked |
| sdaDrvLow | output | 1 | 1 pulls the data line low |

## Verification
A wrong bit counter or state shows up within one byte on the bus. The acknowledge then lands in the wrong clock, or it is missing or spurious on the next select or address byte. A bad address pointer or page offset stays hidden until a later read, where it appears as a wrong byte or a wrong wrap position. A write-cycle timer that runs too short or too long only becomes visible as an early or late acknowledge of the device select after a STOP. For that reason the select is probed both right after the STOP and after the delay.

// File: rtl/eeprom2w_pkg.sv
package eeprom2w_pkg;

  // Strobes from the bus controller to the datapath, one cycle wide.
  typedef struct packed {
    logic startSeen;   // START or repeated START seen
    logic loadAddr;    // word-address byte complete
    logic wrByte;      // data byte received in a write
    logic rdAdvance;   // a read byte has been shifted out
    logic commit;      // STOP that ends a write transfer
  } ctrlStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA
  } busState_t;

endpackage

// File: rtl/eeprom2w_ctrl.sv
module eeprom2w_ctrl
  import eeprom2w_pkg::*;
#(
  parameter int ADDR_W  = 9,
  parameter int HI_BITS = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [2:0]        selPins,
  input  logic              busy,
  input  logic [7:0]        rdByte,
  output ctrlStrobes_t      strobes,
  output logic [7:0]        rxByte,
  output logic [ADDR_W-1:0] addrLoad,
  output logic              sdaDrvLow
);

  localparam logic [2:0] PIN_MASK = 3'(3'b111 << HI_BITS);

  logic sclQ, sdaQ;
  logic sclRise, sclFall, startCond, stopCond;
  busState_t state;
  logic [3:0] bitCnt;
  logic ackPhase, slaveAck, masterAck, drvLow;
  logic [7:0] shiftReg;
  logic [6:0] txShift;
  logic byteDone, ackEnd, pinsOk, devMatch, devAccept;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
    end else begin
      sclQ <= sclIn;
      sdaQ <= sdaIn;
    end
  end

  assign sclRise   = sclIn & ~sclQ;
  assign sclFall   = ~sclIn & sclQ;
  assign startCond = sclIn & sclQ & sdaQ & ~sdaIn;
  assign stopCond  = sclIn & sclQ & ~sdaQ & sdaIn;

  assign byteDone  = sclFall & ~ackPhase & (bitCnt == 4'd8) & (state != ST_IDLE);
  assign ackEnd    = sclFall & ackPhase & (bitCnt == 4'd9);
  assign pinsOk    = ((shiftReg[3:1] ^ selPins) & PIN_MASK) == 3'b000;
  assign devMatch  = (shiftReg[7:4] == 4'b1010) && pinsOk && !busy;
  assign devAccept = byteDone && (state == ST_DEV) && devMatch;

  assign rxByte    = shiftReg;
  assign sdaDrvLow = drvLow;

  // The upper word-address bits ride in the select byte for large arrays.
  generate
    if (HI_BITS > 0) begin : g_hiAddr
      logic [HI_BITS-1:0] hiQ;
      always_ff @(posedge clk) begin
        if (!rstN) hiQ <= '0;
        else if (devAccept) hiQ <= shiftReg[HI_BITS:1];
      end
      assign addrLoad = {hiQ, shiftReg};
    end else begin : g_loAddr
      assign addrLoad = shiftReg[ADDR_W-1:0];
    end
  endgenerate

  always_comb begin
    strobes           = '0;
    strobes.startSeen = startCond;
    strobes.commit    = stopCond && (state == ST_WDATA);
    if (byteDone) begin
      case (state)
        ST_ADDR:  strobes.loadAddr  = 1'b1;
        ST_WDATA: strobes.wrByte    = 1'b1;
        ST_RDATA: strobes.rdAdvance = 1'b1;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      ackPhase  <= 1'b0;
      slaveAck  <= 1'b0;
      masterAck <= 1'b0;
      drvLow    <= 1'b0;
      shiftReg  <= '0;
      txShift   <= '0;
    end else if (startCond) begin
      state    <= ST_DEV;
      bitCnt   <= '0;
      ackPhase <= 1'b0;
      drvLow   <= 1'b0;
    end else if (stopCond) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      ackPhase <= 1'b0;
      drvLow   <= 1'b0;
    end else if (state != ST_IDLE) begin
      if (sclRise) begin
        if (!ackPhase && bitCnt < 4'd8) begin
          shiftReg <= {shiftReg[6:0], sdaIn};
          bitCnt   <= bitCnt + 4'd1;
        end else if (ackPhase && bitCnt == 4'd8) begin
          bitCnt <= 4'd9;
          if (!slaveAck) masterAck <= ~sdaIn;
        end
      end else if (sclFall) begin
        if (byteDone) begin
          case (state)
            ST_DEV: begin
              if (devMatch) begin
                drvLow    <= 1'b1;
                ackPhase  <= 1'b1;
                slaveAck  <= 1'b1;
                masterAck <= 1'b1;
                state     <= shiftReg[0] ? ST_RDATA : ST_ADDR;
              end else begin
                drvLow <= 1'b0;
                state  <= ST_IDLE;
              end
            end
            ST_ADDR: begin
              drvLow   <= 1'b1;
              ackPhase <= 1'b1;
              slaveAck <= 1'b1;
              state    <= ST_WDATA;
            end
            ST_WDATA: begin
              drvLow   <= 1'b1;
              ackPhase <= 1'b1;
              slaveAck <= 1'b1;
            end
            default: begin
              drvLow   <= 1'b0;
              ackPhase <= 1'b1;
              slaveAck <= 1'b0;
            end
          endcase
        end else if (ackEnd) begin
          ackPhase <= 1'b0;
          slaveAck <= 1'b0;
          bitCnt   <= '0;
          if (state == ST_RDATA && masterAck) begin
            drvLow  <= ~rdByte[7];
            txShift <= rdByte[6:0];
          end else begin
            drvLow <= 1'b0;
            if (state == ST_RDATA) state <= ST_IDLE;
          end
        end else if (state == ST_RDATA && !ackPhase &&
                     bitCnt >= 4'd1 && bitCnt <= 4'd7) begin
          drvLow  <= ~txShift[6];
          txShift <= {txShift[5:0], 1'b0};
        end
      end
    end
  end

  // R11: the data line only moves while the bus clock is low
  a_r11_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(drvLow) |-> !sclIn);

  // R2: a wrong fixed prefix is never acknowledged
  a_r2_prefix_nack: assert property (@(posedge clk) disable iff (!rstN)
    (byteDone && state == ST_DEV && shiftReg[7:4] != 4'b1010) |=> !sdaDrvLow);

  // R6: no acknowledge of the select byte during the internal write cycle
  a_r6_busy_nack: assert property (@(posedge clk) disable iff (!rstN)
    (byteDone && state == ST_DEV && busy) |=> !sdaDrvLow);

endmodule

// File: rtl/eeprom2w_dp.sv
module eeprom2w_dp
  import eeprom2w_pkg::*;
#(
  parameter int MEM_BYTES  = 512,
  parameter int PAGE_BYTES = 16,
  parameter int WR_CYCLES  = 250000,
  parameter int ADDR_W     = 9,
  parameter int PG_W       = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [7:0]        rxByte,
  input  logic [ADDR_W-1:0] addrLoad,
  input  logic              wpIn,
  output logic              busy,
  output logic [7:0]        rdByte
);

  localparam int TMR_W = $clog2(WR_CYCLES + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(WR_CYCLES - 1);
  localparam int PGN_W = ADDR_W - PG_W;

  logic [7:0] mem [MEM_BYTES];
  logic [7:0] pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pageMask;
  logic [ADDR_W-1:0] addrPtr;
  logic [PGN_W-1:0] commitPage;
  logic [TMR_W-1:0] timer;
  logic [PG_W-1:0] offset, offNext;
  logic commitNow;

  assign offset    = addrPtr[PG_W-1:0];
  assign offNext   = offset + PG_W'(1);
  assign commitNow = busy && (timer == TMR_LAST);
  assign rdByte    = mem[addrPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrPtr    <= '0;
      pageMask   <= '0;
      busy       <= 1'b0;
      timer      <= '0;
      commitPage <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pageBuf[i] <= 8'h00;
    end else begin
      if (strobes.loadAddr) begin
        addrPtr  <= addrLoad;
        pageMask <= '0;
      end else if (strobes.wrByte) begin
        addrPtr <= {addrPtr[ADDR_W-1:PG_W], offNext};
        if (!wpIn && !busy) begin
          pageBuf[offset]  <= rxByte;
          pageMask[offset] <= 1'b1;
        end
      end else if (strobes.rdAdvance) begin
        addrPtr <= addrPtr + ADDR_W'(1);
      end
      if (strobes.startSeen && !busy) pageMask <= '0;
      if (strobes.commit && !busy && pageMask != '0) begin
        busy       <= 1'b1;
        timer      <= '0;
        commitPage <= addrPtr[ADDR_W-1:PG_W];
      end else if (busy) begin
        if (timer == TMR_LAST) begin
          busy     <= 1'b0;
          pageMask <= '0;
        end else begin
          timer <= timer + TMR_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
    end else if (commitNow) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (pageMask[i]) mem[{commitPage, PG_W'(i)}] <= pageBuf[i];
    end
  end

  // R5: page writes never leave the current page
  a_r5_page_wrap: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrByte |=> $stable(addrPtr[ADDR_W-1:PG_W]));

  // R7: protected data bytes leave the page buffer untouched
  a_r7_wp_no_buffer: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrByte && wpIn) |=> $stable(pageMask));

  // R4: a write cycle only runs with buffered bytes to commit
  a_r4_busy_has_data: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (pageMask != '0));

endmodule

// File: rtl/eeprom2w_slave.sv
module eeprom2w_slave
  import eeprom2w_pkg::*;
#(
  parameter int MEM_BYTES = 512,
  parameter int WR_CYCLES = 250000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] selPins,
  input  logic       wpIn,
  output logic       sdaDrvLow
);

  localparam int ADDR_W     = $clog2(MEM_BYTES);
  localparam int PAGE_BYTES = (MEM_BYTES <= 256) ? 8 : 16;
  localparam int PG_W       = $clog2(PAGE_BYTES);
  localparam int HI_BITS    = (ADDR_W > 8) ? ADDR_W - 8 : 0;

  ctrlStrobes_t strobes;
  logic [7:0] rxByte, rdByte;
  logic [ADDR_W-1:0] addrLoad;
  logic busy;

  eeprom2w_ctrl #(.ADDR_W(ADDR_W), .HI_BITS(HI_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .selPins(selPins), .busy(busy), .rdByte(rdByte),
    .strobes(strobes), .rxByte(rxByte), .addrLoad(addrLoad),
    .sdaDrvLow(sdaDrvLow)
  );

  eeprom2w_dp #(
    .MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES), .WR_CYCLES(WR_CYCLES),
    .ADDR_W(ADDR_W), .PG_W(PG_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rxByte(rxByte),
    .addrLoad(addrLoad), .wpIn(wpIn), .busy(busy), .rdByte(rdByte)
  );

endmodule

// File: tb/tb_eeprom2w_slave.sv
module tb_eeprom2w_slave;

  localparam int MEM = 512;
  localparam int WRC = 200;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN = 1'b0, scl = 1'b1, sdaM = 1'b1, wp = 1'b0;
  logic [2:0] pins = 3'b101;
  logic sdaDrvLow, sdaLine;
  assign sdaLine = sdaM & ~sdaDrvLow;

  eeprom2w_slave #(.MEM_BYTES(MEM), .WR_CYCLES(WRC)) dut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine),
    .selPins(pins), .wpIn(wp), .sdaDrvLow(sdaDrvLow)
  );

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] dev(input logic a8, input logic rw);
    return {4'b1010, 2'b10, a8, rw};
  endfunction

  task automatic busStart();
    sdaM = 1'b1; tick(2); scl = 1'b1; tick(4); sdaM = 1'b0; tick(4); scl = 1'b0; tick(2);
  endtask

  task automatic busStop();
    scl = 1'b0; tick(2); sdaM = 1'b0; tick(2); scl = 1'b1; tick(4); sdaM = 1'b1; tick(4);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      scl = 1'b0; tick(2); sdaM = b[i]; tick(2); scl = 1'b1; tick(4);
    end
    scl = 1'b0; tick(2); sdaM = 1'b1; tick(2); scl = 1'b1; tick(2);
    ack = sdaDrvLow; tick(2); scl = 1'b0; tick(2);
  endtask

  task automatic recvByte(input bit mack, output logic [7:0] b, output bit stable);
    bit s1, s2;
    stable = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      scl = 1'b0; tick(2); sdaM = 1'b1; tick(2); scl = 1'b1; tick(1);
      s1 = ~sdaDrvLow; tick(2); s2 = ~sdaDrvLow;
      if (s1 != s2) stable = 1'b0;
      b[i] = s1; tick(1);
    end
    scl = 1'b0; tick(2); sdaM = ~mack; tick(2); scl = 1'b1; tick(4);
    scl = 1'b0; tick(2); sdaM = 1'b1;
  endtask

  task automatic writeBytes(input int addr, input int n, input string req);
    bit a;
    busStart();
    sendByte(dev(addr[8], 1'b0), a); chk({req, " select ack"}, a, 1);
    sendByte(addr[7:0], a);          chk({"R3 ", req, " address ack"}, a, 1);
    for (int i = 0; i < n; i++) begin
      sendByte(wbuf[i], a);          chk({"R3 ", req, " data ack"}, a, 1);
    end
    busStop();
  endtask

  task automatic readSeq(input int addr, input int n, input string req);
    bit a, st;
    busStart();
    sendByte(dev(addr[8], 1'b0), a); chk({"R8 ", req, " select ack"}, a, 1);
    sendByte(addr[7:0], a);          chk({"R8 ", req, " address ack"}, a, 1);
    busStart();
    sendByte(dev(1'b0, 1'b1), a);    chk({"R8 ", req, " read select ack"}, a, 1);
    for (int i = 0; i < n; i++) begin
      recvByte(i != n - 1, rbuf[i], st);
      chk("R11 output stable while clock high", st, 1);
    end
    busStop();
  endtask

  task automatic probeSelect(input int exp, input string req);
    bit a;
    busStart();
    sendByte(dev(1'b0, 1'b0), a);
    chk(req, a, exp);
    busStop();
  endtask

  task automatic waitWrite();
    tick(WRC + 40);
  endtask

  task automatic t_reset();
    chk("R1 line released after reset", sdaDrvLow, 0);
    readSeq(0, 1, "R1");
    chk("R1 erased byte at 0x000", rbuf[0], 8'hFF);
    readSeq(9'h1AB, 1, "R1");
    chk("R1 erased byte at 0x1AB", rbuf[0], 8'hFF);
  endtask

  task automatic t_select();
    bit a;
    busStart(); sendByte({4'b1010, 2'b01, 1'b0, 1'b0}, a); busStop();
    chk("R2 select with wrong pins nacked", a, 0);
    busStart(); sendByte({4'b1011, 2'b10, 1'b0, 1'b0}, a); busStop();
    chk("R2 select with wrong prefix nacked", a, 0);
    chk("R2 line released after nack", sdaDrvLow, 0);
    probeSelect(1, "R2 matching select acked");
  endtask

  task automatic t_byteWrite();
    wbuf[0] = 8'h5A;
    writeBytes(9'h123, 1, "R4");
    probeSelect(0, "R6 select nacked during write cycle");
    waitWrite();
    probeSelect(1, "R6 select acked after write cycle");
    readSeq(9'h123, 1, "R4");
    chk("R4 byte 0x123 after write", rbuf[0], 8'h5A);
    readSeq(9'h023, 1, "R2");
    chk("R2 address bit 8 from select byte keeps 0x023 erased", rbuf[0], 8'hFF);
  endtask

  task automatic t_page();
    logic [7:0] exp [16];
    for (int i = 0; i < 16; i++) exp[i] = 8'hFF;
    for (int i = 0; i < 6; i++) begin
      wbuf[i] = 8'h10 + 8'(i);
      exp[(12 + i) % 16] = 8'h10 + 8'(i);
    end
    writeBytes(9'h03C, 6, "R5");
    waitWrite();
    readSeq(9'h030, 16, "R5");
    for (int i = 0; i < 16; i++)
      chk($sformatf("R5 R9 page byte offset %0d", i), rbuf[i], exp[i]);
  endtask

  task automatic t_current();
    bit a, st;
    readSeq(9'h03C, 1, "R8");
    chk("R8 random read 0x03C", rbuf[0], 8'h10);
    busStart();
    sendByte(dev(1'b0, 1'b1), a); chk("R10 current read select ack", a, 1);
    recvByte(1'b0, rbuf[0], st);
    busStop();
    chk("R10 current read returns 0x03D", rbuf[0], 8'h11);
  endtask

  task automatic t_wrap();
    wbuf[0] = 8'h99;
    writeBytes(9'h000, 1, "R9");
    waitWrite();
    readSeq(9'h1FF, 2, "R9");
    chk("R9 last address byte", rbuf[0], 8'hFF);
    chk("R9 wrap to address 0", rbuf[1], 8'h99);
  endtask

  task automatic t_protect();
    wp = 1'b1;
    wbuf[0] = 8'hAB;
    wbuf[1] = 8'hCD;
    writeBytes(9'h050, 2, "R7");
    probeSelect(1, "R7 no write cycle under protect");
    wp = 1'b0;
    readSeq(9'h050, 2, "R7");
    chk("R7 protected byte 0x050 unchanged", rbuf[0], 8'hFF);
    chk("R7 protected byte 0x051 unchanged", rbuf[1], 8'hFF);
  endtask

  initial begin
    tick(5);
    rstN = 1'b1;
    tick(5);
    t_reset();
    t_select();
    t_byteWrite();
    t_page();
    t_current();
    t_wrap();
    t_protect();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule